// File: doc/BRIEF.md
# Receive Buffer Latency Flush Timer

This block sits beside a UART receive FIFO and decides when its contents must be handed to the host-side reader. A full packet is not always going to form, so a programmable millisecond timer bounds how long a partly filled buffer may wait. The timer advances on a 1 ms tick input, restarts on every byte written into the FIFO, and is parked at zero whenever the FIFO is empty. When it runs out while data is waiting, the block raises a flush request. The request holds until the reader acknowledges it.

A FIFO that fills up to the packet threshold asks for transfer at once, whatever the timer holds. A one-bit cause output tells the reader which path raised the current request. The timeout is an 8-bit millisecond count written through a simple strobe-and-data pair. A written zero is treated as 1 ms. After reset the timeout is 16 ms.

Top module: `rxft_flush_timer`

## Requirements
- R1: After reset `flush_req` and `flush_by_timer` are 0, and the timeout setting is 16.
- R2: A write with `cfg_wr`=1 loads `cfg_data` as timeout N (1..255). With data present and no restart, the request is raised on the clock edge of the Nth `ms_tick` counted since the last restart. It is visible in the cycle after that tick.
- R3: Writing 0 to the timeout gives a setting of 1, so the request follows the first counted tick.
- R4: While `fifo_level` is 0 the tick count is held at zero and no timed request is raised. Ticks seen while empty do not count later.
- R5: A cycle with `byte_wr`=1 restarts the count from zero. A tick in that same cycle is not counted.
- R6: A request raised by the timer drives `flush_by_timer`=1.
- R7: If `fifo_level` >= `PKT_THRESH` (default 62) and no request is pending, `flush_req` rises on the next edge with `flush_by_timer`=0. This does not depend on the timer. In a cycle where both paths would fire, the threshold path wins.
- R8: Once raised, `flush_req` and `flush_by_timer` hold until `flush_ack`. Ticks, byte writes and level changes have no effect on them while the request is pending.
- R9: `flush_ack`=1 clears `flush_req` on the next edge and zeroes the tick count. It takes priority over any request condition in the same cycle. A new timed request then needs a full N ticks.
- R10: `fifo_level` is 9 bits wide, enough for the 384-byte depth (values 0..384). A completely full FIFO at 384 counts as having reached the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cfg_wr | input | 1 | Timeout setting write strobe |
| cfg_data | input | 8 | Timeout in milliseconds (0 treated as 1) |
| fifo_level | input | 9 | Current receive FIFO fill level |
| byte_wr | input | 1 | A byte was written into the FIFO this cycle |
| flush_ack | input | 1 | Reader accepted the pending flush |
| flush_req | output | 1 | Flush request, held until acknowledged |
| flush_by_timer | output | 1 | 1 when the pending request came from the timer, 0 when from the threshold |

## Verification
The hardest situation to reach from the ports is the exact tick on which the timer expires, for every timeout value. This matters most at the ends of the range: a clamped zero, 1, and 255. The stimulus covers all 256 values written to the register. For each value it empties the FIFO, writes one byte, and counts single ticks until the request appears, comparing that count with the clamped setting. Same-cycle collisions are also produced on purpose: a byte write with a tick, an acknowledge with a would-be expiry, and the threshold with an expiry. These show which input has priority.

// File: rtl/rxft_pkg.sv
package rxft_pkg;

   localparam int unsigned TMO_W = 8;

   typedef logic [TMO_W-1:0] tmo_t;

   typedef enum logic {
      SRC_LEVEL = 1'b0,
      SRC_TIMER = 1'b1
   } flush_src_e;

   function automatic tmo_t clamp_tmo(input tmo_t v);
      return (v == '0) ? tmo_t'(1) : v;
   endfunction

endpackage

// File: rtl/rxft_tmo_reg.sv
module rxft_tmo_reg
   import rxft_pkg::*;
#(
   parameter int unsigned TMO_DEFAULT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  tmo_t cfg_data,
   output tmo_t tmo_q
);

   localparam int unsigned TMO_MAX = (1 << TMO_W) - 1;

   if (TMO_DEFAULT < 1 || TMO_DEFAULT > TMO_MAX) begin : g_bad_default
      $error("rxft_tmo_reg: TMO_DEFAULT out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         tmo_q <= tmo_t'(TMO_DEFAULT);
      else if (cfg_wr)
         tmo_q <= clamp_tmo(cfg_data);
   end

   AST_TMO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q != '0); // R3

   AST_TMO_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(tmo_q)); // R2

endmodule

// File: rtl/rxft_ms_timer.sv
module rxft_ms_timer
   import rxft_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic byte_wr,
   input  logic has_data,
   input  logic hold,
   input  logic clear,
   input  tmo_t tmo,
   output logic expire
);

   tmo_t             cnt_q;
   logic [TMO_W:0]   cnt_inc;
   logic             run;
   logic             restart;

   assign restart = !has_data || byte_wr || clear;
   assign run     = !restart && !hold;
   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign expire  = run && ms_tick && (cnt_inc >= {1'b0, tmo});

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (run && ms_tick)
         cnt_q <= expire ? '0 : cnt_inc[TMO_W-1:0];
   end

   AST_EMPTY_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      !has_data |=> cnt_q == '0); // R4

   AST_BYTE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      byte_wr |=> cnt_q == '0); // R5

   AST_PENDING_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      hold && !restart |=> $stable(cnt_q)); // R8

   AST_NO_TICK_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_tick && !restart |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/rxft_req_ctrl.sv
module rxft_req_ctrl
   import rxft_pkg::*;
#(
   parameter int unsigned LEVEL_W    = 9,
   parameter int unsigned PKT_THRESH = 62
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] level,
   input  logic               expire,
   input  logic               ack,
   output logic               req,
   output flush_src_e         src
);

   logic level_full;

   if (PKT_THRESH == 0) begin : g_no_thresh
      assign level_full = 1'b0;
   end else begin : g_thresh
      assign level_full = (level >= LEVEL_W'(PKT_THRESH));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req <= 1'b0;
         src <= SRC_LEVEL;
      end else if (ack) begin
         req <= 1'b0;
         src <= SRC_LEVEL;
      end else if (!req) begin
         if (level_full) begin
            req <= 1'b1;
            src <= SRC_LEVEL;
         end else if (expire) begin
            req <= 1'b1;
            src <= SRC_TIMER;
         end
      end
   end

   AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req && $stable(src)); // R8

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !req); // R9

   if (PKT_THRESH != 0) begin : g_thresh_chk
      AST_FULL_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
         (level >= LEVEL_W'(PKT_THRESH)) && !ack && !req |=> req && src == SRC_LEVEL); // R7
   end

endmodule

// File: rtl/rxft_flush_timer.sv
module rxft_flush_timer
   import rxft_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH  = 384,
   parameter int unsigned PKT_THRESH  = 62,
   parameter int unsigned TMO_DEFAULT = 16,
   localparam int unsigned LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ms_tick,
   input  logic               cfg_wr,
   input  logic [7:0]         cfg_data,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic               byte_wr,
   input  logic               flush_ack,
   output logic               flush_req,
   output logic               flush_by_timer
);

   if (PKT_THRESH > FIFO_DEPTH) begin : g_bad_thresh
      $error("rxft_flush_timer: PKT_THRESH exceeds FIFO_DEPTH");
   end
   if (TMO_W != 8) begin : g_bad_width
      $error("rxft_flush_timer: timeout width must match cfg_data");
   end

   tmo_t       tmo;
   logic       expire;
   logic       has_data;
   flush_src_e src;

   assign has_data       = (fifo_level != '0);
   assign flush_by_timer = (src == SRC_TIMER);

   rxft_tmo_reg #(
      .TMO_DEFAULT (TMO_DEFAULT)
   ) i_tmo_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_data (cfg_data),
      .tmo_q    (tmo)
   );

   rxft_ms_timer i_ms_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ms_tick  (ms_tick),
      .byte_wr  (byte_wr),
      .has_data (has_data),
      .hold     (flush_req),
      .clear    (flush_ack),
      .tmo      (tmo),
      .expire   (expire)
   );

   rxft_req_ctrl #(
      .LEVEL_W    (LEVEL_W),
      .PKT_THRESH (PKT_THRESH)
   ) i_req_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (fifo_level),
      .expire (expire),
      .ack    (flush_ack),
      .req    (flush_req),
      .src    (src)
   );

   AST_TIMED_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_req) && flush_by_timer |-> $past(fifo_level != '0)); // R4

   AST_TIMED_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_req) && flush_by_timer |-> $past(ms_tick)); // R6

endmodule

// File: tb/test_rxft_flush_timer.sv
module test_rxft_flush_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_data = '0;
   logic [8:0] fifo_level = '0;
   logic       byte_wr = 1'b0;
   logic       flush_ack = 1'b0;
   logic       flush_req;
   logic       flush_by_timer;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rxft_flush_timer i_rxft_flush_timer (
      .clk            (clk),
      .rst_n          (rst_n),
      .ms_tick        (ms_tick),
      .cfg_wr         (cfg_wr),
      .cfg_data       (cfg_data),
      .fifo_level     (fifo_level),
      .byte_wr        (byte_wr),
      .flush_ack      (flush_ack),
      .flush_req      (flush_req),
      .flush_by_timer (flush_by_timer)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
   endtask

   task automatic set_tmo(input int v);
      @(negedge clk) begin cfg_wr = 1'b1; cfg_data = v[7:0]; end
      @(negedge clk) cfg_wr = 1'b0;
   endtask

   task automatic put_byte(input int lvl);
      @(negedge clk) begin fifo_level = lvl[8:0]; byte_wr = 1'b1; end
      @(negedge clk) byte_wr = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk) flush_ack = 1'b1;
      @(negedge clk) flush_ack = 1'b0;
   endtask

   // Counts ticks until the request appears (returns 999 if none in 300)
   task automatic count_ticks(output int k);
      k = 999;
      for (int i = 1; i <= 300; i++) begin
         tick();
         if (flush_req) begin
            k = i;
            break;
         end
      end
   endtask

   int k;

   initial begin
      repeat (3) step();
      @(negedge clk) rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 req after reset", flush_req, 0);
      chk("R1 cause after reset", flush_by_timer, 0);
      put_byte(1);
      count_ticks(k);
      chk("R1 default timeout 16", k, 16);
      chk("R6 cause timer", flush_by_timer, 1);
      do_ack();
      chk("R9 ack clears", flush_req, 0);

      // R2 / R3 sweep of every register value
      for (int n = 0; n < 256; n++) begin
         @(negedge clk) fifo_level = '0;
         set_tmo(n);
         put_byte(1);
         count_ticks(k);
         chk(n == 0 ? "R3 zero clamps to 1" : "R2 tick count", k, (n == 0) ? 1 : n);
         chk("R6 timer cause", flush_by_timer, 1);
         do_ack();
      end

      // R4 ticks while empty do not count
      @(negedge clk) fifo_level = '0;
      set_tmo(5);
      for (int i = 0; i < 40; i++) tick();
      chk("R4 no request while empty", flush_req, 0);
      @(negedge clk) fifo_level = 9'd2;
      count_ticks(k);
      chk("R4 count starts fresh", k, 5);
      do_ack();

      // R5 restart by byte write
      @(negedge clk) fifo_level = '0;
      set_tmo(10);
      put_byte(3);
      for (int i = 0; i < 7; i++) tick();
      chk("R5 not yet", flush_req, 0);
      put_byte(4);
      count_ticks(k);
      chk("R5 restart by byte", k, 10);
      do_ack();
      @(negedge clk) fifo_level = '0;
      put_byte(3);
      for (int i = 0; i < 9; i++) tick();
      @(negedge clk) begin ms_tick = 1'b1; byte_wr = 1'b1; end
      @(negedge clk) begin ms_tick = 1'b0; byte_wr = 1'b0; end
      chk("R5 same-cycle tick ignored", flush_req, 0);
      count_ticks(k);
      chk("R5 full period after restart", k, 10);
      do_ack();

      // R7 threshold path
      @(negedge clk) fifo_level = 9'd61;
      step(); step();
      chk("R7 below threshold", flush_req, 0);
      @(negedge clk) fifo_level = 9'd62;
      step();
      chk("R7 threshold request", flush_req, 1);
      chk("R7 threshold cause", flush_by_timer, 0);
      @(negedge clk) begin flush_ack = 1'b1; end
      @(negedge clk) flush_ack = 1'b0;
      chk("R9 ack beats threshold", flush_req, 0);
      step();
      chk("R7 threshold re-requests", flush_req, 1);
      @(negedge clk) begin fifo_level = 9'd1; flush_ack = 1'b1; end
      @(negedge clk) flush_ack = 1'b0;
      set_tmo(1);
      put_byte(1);
      @(negedge clk) begin ms_tick = 1'b1; fifo_level = 9'd62; end
      @(negedge clk) ms_tick = 1'b0;
      chk("R7 threshold beats expiry", flush_by_timer, 0);
      chk("R7 request present", flush_req, 1);
      @(negedge clk) begin fifo_level = 9'd1; flush_ack = 1'b1; end
      @(negedge clk) flush_ack = 1'b0;

      // R10 full FIFO level
      @(negedge clk) fifo_level = 9'd384;
      step();
      chk("R10 full 384 requests", flush_req, 1);
      chk("R10 full cause", flush_by_timer, 0);
      @(negedge clk) begin fifo_level = 9'd1; flush_ack = 1'b1; end
      @(negedge clk) flush_ack = 1'b0;

      // R8 sticky while pending
      @(negedge clk) fifo_level = '0;
      set_tmo(3);
      put_byte(2);
      count_ticks(k);
      chk("R8 pre request", k, 3);
      for (int i = 0; i < 20; i++) begin
         tick();
         put_byte(5);
      end
      @(negedge clk) fifo_level = 9'd100;
      step();
      @(negedge clk) fifo_level = '0;
      step();
      chk("R8 still pending", flush_req, 1);
      chk("R8 cause unchanged", flush_by_timer, 1);

      // R9 ack with a tick in the same cycle, then fresh period
      put_byte(1);
      set_tmo(1);
      @(negedge clk) begin flush_ack = 1'b1; ms_tick = 1'b1; end
      @(negedge clk) begin flush_ack = 1'b0; ms_tick = 1'b0; end
      chk("R9 ack beats tick", flush_req, 0);
      count_ticks(k);
      chk("R9 next tick requests", k, 1);
      do_ack();
      set_tmo(4);
      count_ticks(k);
      chk("R9 full period after ack", k, 4);
      do_ack();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL R1-watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule